// File: doc/BRIEF.md
# Programmable-Priority Memory Bus Arbiter

This block decides which of four bus masters may use a shared single-port data memory in a given access. The four masters are a processor port, a USB port, a DMA port and a debug port. When several of them request in the same cycle, the block grants the one with the highest priority. The others keep their requests pending and win later, once the current holder is finished. The grant is registered. It is shown both as a one-hot vector and as a two-bit master index. It stays in place until the granted master pulses its done line, so an access that has started is never pre-empted.

A 16-bit priority control word sets the ordering. Bit 3 moves the USB master above the processor, and bit 5 moves the DMA master above the processor. Masters that are promoted together keep USB ahead of DMA. Masters that are not promoted keep USB ahead of DMA below the processor. The debug master is always last. The control word may change at any time, and it takes effect at the next arbitration. Any control word with a bit set outside bits 3 and 5 is illegal. Such a word raises a sticky error flag, which only reset clears, and the block arbitrates as if the control word were zero.

Top module: `bus_prio_arbiter`

## Requirements
- R1: During and straight after reset, `gnt` is 0, `gnt_idx` is 0 and `cfg_err` is 0.
- R2: If no grant is held and `req` is 0 at a clock edge, `gnt` stays 0 after that edge.
- R3: If no grant is held and at least one request is present at a clock edge, `gnt` is one-hot on exactly one requesting master after that edge. Bit positions are processor 0, USB 1, DMA 2, debug 3.
- R4: With control 0x0000 the order from highest to lowest is processor, USB, DMA, debug.
- R5: With control 0x0008 the order is USB, processor, DMA, debug.
- R6: With control 0x0020 the order is DMA, processor, USB, debug.
- R7: With control 0x0028 the order is USB, DMA, processor, debug.
- R8: The debug master is granted only when no other master requests.
- R9: A held grant does not change while the granted master's done bit is low. This holds whatever the other requests, the done bits of other masters or changes to the control word do.
- R10: A clock edge with done high for the granted master clears `gnt` and `gnt_idx` to 0. The masters still pending are then arbitrated at the next edge.
- R11: A control value with any bit set outside bits 3 and 5 sets `cfg_err` one edge later. The flag stays set until reset, and arbitration uses the 0x0000 order.
- R12: While a grant is held, `gnt_idx` gives the bit position of the set bit in `gnt`. While no grant is held, `gnt_idx` is 0.
- R13: A new control word does not affect the grant being held. It decides the next arbitration after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_ctrl | input | 16 | Priority control word |
| req | input | 4 | Request per master (processor, USB, DMA, debug) |
| done | input | 4 | Access-finished pulse per master |
| gnt | output | 4 | Registered one-hot grant |
| gnt_idx | output | 2 | Index of the granted master |
| cfg_err | output | 1 | Sticky illegal-control flag |

## Verification
A wrong rank decode shows up one edge after a contested request: the wrong bit of `gnt` rises. Sweeping every request pattern under each legal and illegal control word therefore exposes each wrong ordering within two cycles. A broken hold register shows up as a grant that moves, or that fails to drop, on the edge after a foreign done or an own done. A lost sticky flag shows up as `cfg_err` falling once the control word returns to a legal value.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
   localparam int NUM_MST = 4;
   localparam int IDX_W   = $clog2(NUM_MST);
   localparam int RANK_W  = 3;

   typedef enum logic [IDX_W-1:0] {
      MST_CPU = 2'd0,
      MST_USB = 2'd1,
      MST_DMA = 2'd2,
      MST_DBG = 2'd3
   } mst_e;

   typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/bpa_order_decode.sv
module bpa_order_decode
   import bpa_pkg::*;
#(
   parameter int CTRL_W  = 16,
   parameter int USB_BIT = 3,
   parameter int DMA_BIT = 5
) (
   input  logic [CTRL_W-1:0]             ctrl,
   output logic [NUM_MST-1:0][RANK_W-1:0] rank,
   output logic                          illegal
);
   localparam logic [CTRL_W-1:0] LEGAL_MASK =
      (CTRL_W'(1) << USB_BIT) | (CTRL_W'(1) << DMA_BIT);

   if (USB_BIT >= CTRL_W || DMA_BIT >= CTRL_W || USB_BIT == DMA_BIT) begin : g_bad_bits
      $error("bpa_order_decode: promote bits out of range or equal");
   end

   logic usb_up, dma_up;

   always_comb begin
      illegal = |(ctrl & ~LEGAL_MASK);
      usb_up  = ctrl[USB_BIT] & ~illegal;
      dma_up  = ctrl[DMA_BIT] & ~illegal;
      rank[MST_DBG] = rank_t'(4);
      unique case ({dma_up, usb_up})
         2'b01: begin
            rank[MST_USB] = rank_t'(0);
            rank[MST_CPU] = rank_t'(1);
            rank[MST_DMA] = rank_t'(3);
         end
         2'b10: begin
            rank[MST_DMA] = rank_t'(0);
            rank[MST_CPU] = rank_t'(1);
            rank[MST_USB] = rank_t'(3);
         end
         2'b11: begin
            rank[MST_USB] = rank_t'(0);
            rank[MST_DMA] = rank_t'(1);
            rank[MST_CPU] = rank_t'(2);
         end
         default: begin
            rank[MST_CPU] = rank_t'(0);
            rank[MST_USB] = rank_t'(2);
            rank[MST_DMA] = rank_t'(3);
         end
      endcase
   end
endmodule

// File: rtl/bpa_pick.sv
module bpa_pick
   import bpa_pkg::*;
#(
   parameter int N  = NUM_MST,
   parameter int RW = RANK_W
) (
   input  logic [N-1:0]         req,
   input  logic [N-1:0][RW-1:0] rank,
   output logic [N-1:0]         win,
   output logic [$clog2(N)-1:0] win_idx
);
   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("bpa_pick: needs at least two masters");
   end

   for (genvar i = 0; i < N; i++) begin : g_cand
      logic beaten;
      always_comb begin
         beaten = 1'b0;
         for (int j = 0; j < N; j++) begin
            if (j != i && req[j] && (rank[j] < rank[i])) beaten = 1'b1;
         end
         win[i] = req[i] & ~beaten;
      end
   end

   always_comb begin
      win_idx = '0;
      for (int k = 0; k < N; k++) begin
         if (win[k]) win_idx = IW'(k);
      end
   end
endmodule

// File: rtl/bpa_grant_reg.sv
module bpa_grant_reg
   import bpa_pkg::*;
#(
   parameter int N = NUM_MST
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         win,
   input  logic [$clog2(N)-1:0] win_idx,
   input  logic [N-1:0]         done,
   output logic [N-1:0]         gnt,
   output logic [$clog2(N)-1:0] gnt_idx
);
   logic busy, release_now;

   assign busy        = |gnt;
   assign release_now = |(gnt & done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt     <= '0;
         gnt_idx <= '0;
      end else if (busy) begin
         if (release_now) begin
            gnt     <= '0;
            gnt_idx <= '0;
         end
      end else if (|win) begin
         gnt     <= win;
         gnt_idx <= win_idx;
      end
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !release_now) |=> (gnt == $past(gnt)));
   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      release_now |=> (gnt == '0 && gnt_idx == '0));
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
   import bpa_pkg::*;
#(
   parameter int CTRL_W  = 16,
   parameter int USB_BIT = 3,
   parameter int DMA_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] prio_ctrl,
   input  logic [3:0]        req,
   input  logic [3:0]        done,
   output logic [3:0]        gnt,
   output logic [1:0]        gnt_idx,
   output logic              cfg_err
);
   logic [NUM_MST-1:0][RANK_W-1:0] rank;
   logic                           illegal;
   logic [NUM_MST-1:0]             win;
   logic [IDX_W-1:0]               win_idx;

   bpa_order_decode #(.CTRL_W(CTRL_W), .USB_BIT(USB_BIT), .DMA_BIT(DMA_BIT)) i_decode (
      .ctrl(prio_ctrl), .rank(rank), .illegal(illegal));

   bpa_pick #(.N(NUM_MST), .RW(RANK_W)) i_pick (
      .req(req), .rank(rank), .win(win), .win_idx(win_idx));

   bpa_grant_reg #(.N(NUM_MST)) i_grant (
      .clk(clk), .rst_n(rst_n), .win(win), .win_idx(win_idx),
      .done(done), .gnt(gnt), .gnt_idx(gnt_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= cfg_err | illegal;
   end

   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0) |=> (gnt == '0));
   p_grant_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req != '0) |=> ((gnt & $past(req)) != '0));
   p_dbg_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req[2:0] != '0) |=> !gnt[3]);
   p_idx_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> gnt[gnt_idx]);
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
endmodule

// File: tb/test_bus_prio_arbiter.sv
`timescale 1ns/1ps
module test_bus_prio_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] prio_ctrl = '0;
   logic [3:0]  req = '0;
   logic [3:0]  done = '0;
   logic [3:0]  gnt;
   logic [1:0]  gnt_idx;
   logic        cfg_err;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   bus_prio_arbiter i_bus_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .prio_ctrl(prio_ctrl), .req(req),
      .done(done), .gnt(gnt), .gnt_idx(gnt_idx), .cfg_err(cfg_err));

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // expected winner: promoted masters (USB before DMA), then processor,
   // then unpromoted (USB before DMA), then debug; illegal word = no promotion
   function automatic int exp_winner(logic [15:0] c, logic [3:0] r);
      int order[4];
      int n = 0;
      bit bad = (c & ~16'h0028) != 0;
      bit u = c[3] && !bad;
      bit d = c[5] && !bad;
      if (u) begin order[n] = 1; n++; end
      if (d) begin order[n] = 2; n++; end
      order[n] = 0; n++;
      if (!u) begin order[n] = 1; n++; end
      if (!d) begin order[n] = 2; n++; end
      order[n] = 3;
      for (int k = 0; k < 4; k++) if (r[order[k]]) return order[k];
      return -1;
   endfunction

   function automatic string tag_for(logic [15:0] c);
      if ((c & ~16'h0028) != 0) return "R11";
      case (c)
         16'h0008: return "R5";
         16'h0020: return "R6";
         16'h0028: return "R7";
         default:  return "R4";
      endcase
   endfunction

   task automatic sweep(logic [15:0] c);
      for (int r = 0; r < 16; r++) begin
         int w;
         @(negedge clk);
         prio_ctrl = c; req = 4'(r); done = '0;
         @(negedge clk);
         w = exp_winner(c, 4'(r));
         if (w < 0) begin
            check("R2 idle no grant", gnt, 0);
         end else begin
            check({tag_for(c), " R3 R8 grant"}, gnt, 1 << w);
            check("R12 index", gnt_idx, w);
         end
         done = gnt; req = '0;
         @(negedge clk);
         check("R10 release", gnt, 0);
         check("R12 idle index", gnt_idx, 0);
         done = '0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset gnt", gnt, 0);
      check("R1 reset idx", gnt_idx, 0);
      check("R1 reset err", cfg_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset gnt", gnt, 0);
      check("R1 after reset err", cfg_err, 0);

      sweep(16'h0000);
      sweep(16'h0008);
      sweep(16'h0020);
      sweep(16'h0028);
      check("R11 legal words leave flag low", cfg_err, 0);

      // hold, foreign done, runtime change without pre-emption
      prio_ctrl = 16'h0000; req = 4'b0001; done = '0;
      @(negedge clk);
      check("R3 processor granted", gnt, 4'b0001);
      req = 4'b0011; done = 4'b0010; prio_ctrl = 16'h0008;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R9 R13 grant held", gnt, 4'b0001);
      end
      done = 4'b0001;
      @(negedge clk);
      check("R10 released", gnt, 0);
      done = '0;
      @(negedge clk);
      check("R13 new order after release", gnt, 4'b0010);
      check("R12 index USB", gnt_idx, 1);
      done = 4'b0010; req = 4'b0001;
      @(negedge clk);
      check("R10 released USB", gnt, 0);
      done = '0;
      @(negedge clk);
      check("R10 pending processor served", gnt, 4'b0001);
      done = 4'b0001; req = '0;
      @(negedge clk);
      done = '0;

      sweep(16'h0001);
      check("R11 flag set", cfg_err, 1);
      sweep(16'h8028);
      prio_ctrl = 16'h0000;
      repeat (3) @(negedge clk);
      check("R11 flag sticky", cfg_err, 1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule